// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Port

This block is a full-duplex asynchronous serial port that carries 8-bit characters. Each direction has two stages. The transmit side has a one-byte holding register in front of a shift register. The receive side has a shift register that delivers into a one-byte holding register. Because of this, software can queue the next byte while the current one is still on the line, and it can read a finished byte while the next one is arriving.

The frame format is set at run time. Parity can be even, odd or off, and the stop field can be one or two bit times. All timing derives from a 16x oversampling tick. That tick is produced by a programmable divider, which counts either every system clock cycle or the rising edges of a slower alternate clock input.

The block reports activity as one-cycle events: byte sent, byte received and receive error. Parity, framing and overrun errors are also kept in sticky flags until they are cleared.

Transmitter states: `TX_IDLE`, `TX_START`, `TX_DATA`, `TX_PARITY`, `TX_STOP1`, `TX_STOP2`.
- `TX_IDLE` moves to `TX_START` when the holding register is full.
- `TX_START` moves to `TX_DATA` after one bit time.
- `TX_DATA` moves to `TX_PARITY` (parity on) or `TX_STOP1` (parity off) after bit 7.
- `TX_PARITY` moves to `TX_STOP1`.
- `TX_STOP1` moves to `TX_STOP2` when two stop bits are selected. Otherwise it moves to `TX_START` if a byte is waiting, or to `TX_IDLE`.
- `TX_STOP2` moves to `TX_START` or `TX_IDLE` by the same rule.

Receiver states: `RX_IDLE`, `RX_START`, `RX_DATA`, `RX_PARITY`, `RX_STOP`.
- `RX_IDLE` moves to `RX_START` on a low line.
- `RX_START` moves to `RX_DATA` if the line is still low at mid start bit. Otherwise it returns to `RX_IDLE`.
- `RX_DATA` moves to `RX_PARITY` or `RX_STOP` after 8 samples.
- `RX_PARITY` moves to `RX_STOP`.
- `RX_STOP` returns to `RX_IDLE` at mid stop bit.

Top module: `duplex_serial_port`

## Requirements
- R1: After reset `txd` is 1. `tx_busy`, `tx_hold_full`, `rx_valid`, all three error flags and all three event outputs are 0.
- R2: A frame is a low start bit, then data bits 0 through 7 (LSB first), then an optional parity bit, then the stop field at 1. While `tx_busy` is 0, `txd` is 1.
- R3: `cfg_parity` encodes the parity mode. 2'b00 is none and 2'b11 is also none. 2'b01 is even: the parity bit makes the count of ones in data plus parity even. 2'b10 is odd: that count is odd.
- R4: `cfg_two_stop`=1 keeps the line high for two bit times after the data or parity bit; 0 keeps it high for one. With the holding register refilled in time, consecutive start bits are exactly (10 + parity enabled + two_stop) bit times apart.
- R5: A bit time is 16*(`cfg_div`+1) source pulses. With `cfg_clk_sel`=0, every system clock cycle is a pulse. With `cfg_clk_sel`=1, each rising edge of `alt_clk` is a pulse.
- R6: `tx_wr` loads `tx_data` into the holding register only while `tx_hold_full` is 0; a write while it is 1 is ignored. The held byte moves into the shifter on the next cycle when the transmitter is idle, or at the end of the current frame.
- R7: `evt_tx_done` pulses for one cycle after the last stop bit of each frame.
- R8: The receiver samples at mid-bit on a 16x tick. A start bit is confirmed at mid start bit, so a low pulse shorter than half a bit is ignored. A finished byte appears on `rx_data` with `rx_valid`=1 and a one-cycle `evt_rx_done`. `rx_rd` clears `rx_valid`.
- R9: A parity mismatch sets sticky `err_parity` and pulses `evt_rx_err`; the byte is still delivered.
- R10: A low first stop bit sets sticky `err_frame` and pulses `evt_rx_err`. The second stop bit is never checked by the receiver.
- R11: A byte that completes while `rx_valid` is 1 is dropped. It sets sticky `err_overrun` and pulses `evt_rx_err`, and the held byte is kept.
- R12: `err_clr` clears all three error flags; an error detected in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alt_clk | input | 1 | Alternate slow clock for the baud divider |
| cfg_clk_sel | input | 1 | 0: divider counts system clocks, 1: counts alt_clk rising edges |
| cfg_div | input | 16 | Divider value; tick every cfg_div+1 source pulses |
| cfg_parity | input | 2 | Parity mode (00/11 none, 01 even, 10 odd) |
| cfg_two_stop | input | 1 | 1 selects two transmitted stop bits |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Byte to transmit |
| tx_hold_full | output | 1 | Transmit holding register occupied |
| tx_busy | output | 1 | Transmitter shifting a frame |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_rd | input | 1 | Read strobe, clears rx_valid |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Receive holding register occupied |
| err_clr | input | 1 | Clears the sticky error flags |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |
| evt_tx_done | output | 1 | One-cycle pulse per transmitted frame |
| evt_rx_done | output | 1 | One-cycle pulse per delivered byte |
| evt_rx_err | output | 1 | One-cycle pulse per erroneous frame |

## Verification
Timing follows a fixed chain of register stages.
- A write is captured at one edge and `tx_hold_full` rises with it. An idle transmitter pulls `txd` low one edge later. After that, each bit lasts 16 ticks, so the bench finds the falling edge and samples every bit 8 and then 16 cycles apart, at the bit centres.
- The receiver puts a two-stage synchronizer in front of its mid-bit sampling. Received data, flags and events are therefore checked at least 20 cycles after the sender's mid-stop point, which clears both the three-cycle pipeline and the half-bit stop window.
- Bit periods under a divider are checked against a window that allows for the unknown phase of the first tick.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

    localparam int unsigned OVERSAMPLE = 16;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_OFF2 = 2'b11
    } par_mode_t;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP1,
        TX_STOP2
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_t;

endpackage

// File: rtl/dsp_baud_tick.sv
module dsp_baud_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alt_clk,
    input  logic             clk_sel,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [2:0]       alt_q;
    logic             src_pulse;
    logic [DIV_W-1:0] cnt;

    // synchronise the slow clock and keep its rising edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) alt_q <= '0;
        else        alt_q <= {alt_q[1:0], alt_clk};
    end

    assign src_pulse = clk_sel ? (alt_q[1] & ~alt_q[2]) : 1'b1;
    assign tick      = src_pulse && (cnt >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (src_pulse) cnt <= (cnt >= div) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/dsp_tx.sv
module dsp_tx
    import dsp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  par_mode_t         par_mode,
    input  logic              two_stop,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              hold_full,
    output logic              busy,
    output logic              txd,
    output logic              done
);
    localparam int OS_W = $clog2(OVERSAMPLE);
    localparam int BI_W = $clog2(DATA_W);
    localparam logic [OS_W-1:0] OS_LAST  = OS_W'(OVERSAMPLE - 1);
    localparam logic [BI_W-1:0] BIT_LAST = BI_W'(DATA_W - 1);

    tx_state_t         state, nxt;
    logic [OS_W-1:0]   os_cnt;
    logic [BI_W-1:0]   bit_idx;
    logic [DATA_W-1:0] shreg, hold_q;
    logic              par_q;
    logic              par_en, bit_end, last_end, load;

    assign par_en   = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
    assign bit_end  = tick && (os_cnt == OS_LAST);
    assign last_end = bit_end && ((state == TX_STOP1 && !two_stop) || state == TX_STOP2);
    assign load     = hold_full && (state == TX_IDLE || last_end);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:   if (hold_full) nxt = TX_START;
            TX_START:  if (bit_end) nxt = TX_DATA;
            TX_DATA:   if (bit_end && bit_idx == BIT_LAST) nxt = par_en ? TX_PARITY : TX_STOP1;
            TX_PARITY: if (bit_end) nxt = TX_STOP1;
            TX_STOP1:  if (bit_end) nxt = two_stop ? TX_STOP2 : (hold_full ? TX_START : TX_IDLE);
            TX_STOP2:  if (bit_end) nxt = hold_full ? TX_START : TX_IDLE;
            default:   nxt = TX_IDLE;
        endcase
    end

    // datapath: holding register, shifter, oversample and bit counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_q    <= '0;
            shreg     <= '0;
            par_q     <= 1'b0;
            os_cnt    <= '0;
            bit_idx   <= '0;
            done      <= 1'b0;
        end else begin
            done <= last_end;
            if (load) begin
                hold_full <= 1'b0;
                shreg     <= hold_q;
                par_q     <= (^hold_q) ^ (par_mode == PAR_ODD);
                bit_idx   <= '0;
            end else if (wr && !hold_full) begin
                hold_full <= 1'b1;
                hold_q    <= wdata;
            end
            if (state == TX_IDLE)  os_cnt <= '0;
            else if (tick)         os_cnt <= os_cnt + 1'b1;
            if (state == TX_DATA && bit_end) begin
                shreg   <= shreg >> 1;
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy = (state != TX_IDLE);
        unique case (state)
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = shreg[0];
            TX_PARITY: txd = par_q;
            default:   txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/dsp_rx.sv
module dsp_rx
    import dsp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  par_mode_t         par_mode,
    input  logic              rxd,
    input  logic              rd,
    input  logic              err_clr,
    output logic [DATA_W-1:0] data,
    output logic              valid,
    output logic              done,
    output logic              err_evt,
    output logic              err_par,
    output logic              err_frm,
    output logic              err_ovr
);
    localparam int OS_W = $clog2(OVERSAMPLE);
    localparam int BI_W = $clog2(DATA_W);
    localparam logic [OS_W-1:0] OS_LAST  = OS_W'(OVERSAMPLE - 1);
    localparam logic [OS_W-1:0] OS_MID   = OS_W'(OVERSAMPLE / 2 - 1);
    localparam logic [BI_W-1:0] BIT_LAST = BI_W'(DATA_W - 1);

    rx_state_t         state, nxt;
    logic [1:0]        sync_q;
    logic              rx_s;
    logic [OS_W-1:0]   os_cnt;
    logic [BI_W-1:0]   bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_bad;
    logic              par_en, mid_start, bit_mid, frame_end, ovr;
    logic              set_par, set_frm, set_ovr;

    assign rx_s      = sync_q[1];
    assign par_en    = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
    assign mid_start = tick && (os_cnt == OS_MID);
    assign bit_mid   = tick && (os_cnt == OS_LAST);
    assign frame_end = (state == RX_STOP) && bit_mid;
    assign ovr       = valid && !rd;
    assign set_par   = frame_end && par_bad;
    assign set_frm   = frame_end && !rx_s;
    assign set_ovr   = frame_end && ovr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:   if (!rx_s) nxt = RX_START;
            RX_START:  if (mid_start) nxt = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:   if (bit_mid && bit_idx == BIT_LAST) nxt = par_en ? RX_PARITY : RX_STOP;
            RX_PARITY: if (bit_mid) nxt = RX_STOP;
            RX_STOP:   if (bit_mid) nxt = RX_IDLE;
            default:   nxt = RX_IDLE;
        endcase
    end

    // sampling datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_cnt  <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_bad <= 1'b0;
        end else begin
            if (state == RX_IDLE || (state == RX_START && mid_start)) os_cnt <= '0;
            else if (tick)                                            os_cnt <= os_cnt + 1'b1;
            if (state == RX_IDLE) begin
                bit_idx <= '0;
                par_bad <= 1'b0;
            end
            if (state == RX_DATA && bit_mid) begin
                shreg   <= {rx_s, shreg[DATA_W-1:1]};
                bit_idx <= bit_idx + 1'b1;
            end
            if (state == RX_PARITY && bit_mid)
                par_bad <= rx_s != ((^shreg) ^ (par_mode == PAR_ODD));
        end
    end

    // outputs: holding register, events, sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data    <= '0;
            valid   <= 1'b0;
            done    <= 1'b0;
            err_evt <= 1'b0;
            err_par <= 1'b0;
            err_frm <= 1'b0;
            err_ovr <= 1'b0;
        end else begin
            done    <= frame_end && !ovr;
            err_evt <= set_par || set_frm || set_ovr;
            err_par <= (err_par && !err_clr) || set_par;
            err_frm <= (err_frm && !err_clr) || set_frm;
            err_ovr <= (err_ovr && !err_clr) || set_ovr;
            if (frame_end && !ovr) begin
                data  <= shreg;
                valid <= 1'b1;
            end else if (rd) begin
                valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/duplex_serial_port.sv
module duplex_serial_port
    import dsp_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alt_clk,
    input  logic              cfg_clk_sel,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [1:0]        cfg_parity,
    input  logic              cfg_two_stop,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_hold_full,
    output logic              tx_busy,
    output logic              txd,
    input  logic              rxd,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              err_clr,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_overrun,
    output logic              evt_tx_done,
    output logic              evt_rx_done,
    output logic              evt_rx_err
);
    logic      tick;
    par_mode_t par_mode;

    assign par_mode = par_mode_t'(cfg_parity);

    dsp_baud_tick #(.DIV_W(DIV_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .alt_clk(alt_clk),
        .clk_sel(cfg_clk_sel), .div(cfg_div), .tick(tick)
    );

    dsp_tx #(.DATA_W(DATA_W)) tx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .par_mode(par_mode),
        .two_stop(cfg_two_stop), .wr(tx_wr), .wdata(tx_data),
        .hold_full(tx_hold_full), .busy(tx_busy), .txd(txd), .done(evt_tx_done)
    );

    dsp_rx #(.DATA_W(DATA_W)) rx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .par_mode(par_mode),
        .rxd(rxd), .rd(rx_rd), .err_clr(err_clr),
        .data(rx_data), .valid(rx_valid), .done(evt_rx_done), .err_evt(evt_rx_err),
        .err_par(err_parity), .err_frm(err_frame), .err_ovr(err_overrun)
    );
endmodule

// File: rtl/dsp_checker.sv
module dsp_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_hold_full,
    input logic tx_busy,
    input logic txd,
    input logic rx_valid,
    input logic err_clr,
    input logic err_parity,
    input logic err_frame,
    input logic err_overrun,
    input logic evt_tx_done,
    input logic evt_rx_done,
    input logic evt_rx_err
);
    AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);                                       // R2
    AST_HOLD_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_hold_full && !tx_busy) |=> !tx_hold_full);           // R6
    AST_TX_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tx_done |=> !evt_tx_done);                           // R7
    AST_RX_EVT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rx_done |-> rx_valid);                               // R8
    AST_FRAME_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_frame) |-> evt_rx_err);                        // R10
    AST_OVERRUN_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> evt_rx_err);                      // R11
    AST_PARITY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_parity && !err_clr) |=> err_parity);                // R12
endmodule

bind duplex_serial_port dsp_checker chk_i (
    .clk(clk), .rst_n(rst_n), .tx_hold_full(tx_hold_full), .tx_busy(tx_busy),
    .txd(txd), .rx_valid(rx_valid), .err_clr(err_clr), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun), .evt_tx_done(evt_tx_done),
    .evt_rx_done(evt_rx_done), .evt_rx_err(evt_rx_err)
);

// File: tb/duplex_serial_port_tb_top.sv
module duplex_serial_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0, rst_n = 1'b0, alt_clk = 1'b0;
    logic        cfg_clk_sel = 1'b0, cfg_two_stop = 1'b0;
    logic [15:0] cfg_div = '0;
    logic [1:0]  cfg_parity = 2'b00;
    logic        tx_wr = 1'b0, rx_rd = 1'b0, err_clr = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        tx_hold_full, tx_busy, txd, rxd, rx_valid;
    logic [7:0]  rx_data;
    logic        err_parity, err_frame, err_overrun;
    logic        evt_tx_done, evt_rx_done, evt_rx_err;
    logic        loop_sel = 1'b1, drv_rxd = 1'b1;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int n_tx = 0, n_rxd = 0, n_rxe = 0;

    assign rxd = loop_sel ? txd : drv_rxd;

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(2*CLK_PERIOD) alt_clk = ~alt_clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (evt_tx_done) n_tx  <= n_tx + 1;
        if (evt_rx_done) n_rxd <= n_rxd + 1;
        if (evt_rx_err)  n_rxe <= n_rxe + 1;
    end

    duplex_serial_port dut_i (
        .clk(clk), .rst_n(rst_n), .alt_clk(alt_clk), .cfg_clk_sel(cfg_clk_sel),
        .cfg_div(cfg_div), .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_hold_full(tx_hold_full), .tx_busy(tx_busy),
        .txd(txd), .rxd(rxd), .rx_rd(rx_rd), .rx_data(rx_data), .rx_valid(rx_valid),
        .err_clr(err_clr), .err_parity(err_parity), .err_frame(err_frame),
        .err_overrun(err_overrun), .evt_tx_done(evt_tx_done), .evt_rx_done(evt_rx_done),
        .evt_rx_err(evt_rx_err)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    function automatic bit par_on(input int pm);
        return (pm == 1) || (pm == 2);
    endfunction

    function automatic bit par_of(input logic [7:0] b, input int pm);
        bit ones = bit'($countones(b) % 2);
        return (pm == 1) ? ones : ~ones;
    endfunction

    task automatic tx_write(input logic [7:0] b);
        tx_wr = 1'b1; tx_data = b;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic wr_free(input logic [7:0] b);
        while (tx_hold_full) @(negedge clk);
        tx_write(b);
    endtask

    task automatic read_pulse();
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    // decode one frame on txd at 16 cycles per bit (cfg_div=0, system clock)
    task automatic expect_frame(input logic [7:0] b, input int pm, input bit two, output int t_fall);
        int   guard = 0;
        logic [7:0] got;
        @(negedge clk);
        while (txd === 1'b1 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        t_fall = cyc;
        repeat (8) @(negedge clk);
        chk("R2 start bit low", int'(txd), 0);
        for (int i = 0; i < 8; i++) begin
            repeat (16) @(negedge clk);
            got[i] = txd;
        end
        chk("R2 data bits LSB first", int'(got), int'(b));
        if (par_on(pm)) begin
            repeat (16) @(negedge clk);
            chk("R3 parity bit", int'(txd), int'(par_of(b, pm)));
        end
        repeat (16) @(negedge clk);
        chk("R4 first stop bit", int'(txd), 1);
        if (two) begin
            repeat (16) @(negedge clk);
            chk("R4 second stop bit", int'(txd), 1);
        end
    endtask

    // drive one frame on rxd at 16 cycles per bit
    task automatic send_rx(input logic [7:0] b, input int pm, input bit flip,
                           input bit stop_ok, input int idle_after);
        drv_rxd = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            drv_rxd = b[i];
            repeat (16) @(negedge clk);
        end
        if (par_on(pm)) begin
            drv_rxd = par_of(b, pm) ^ flip;
            repeat (16) @(negedge clk);
        end
        if (stop_ok) begin
            drv_rxd = 1'b1;
            repeat (16) @(negedge clk);
        end else begin
            drv_rxd = 1'b0;
            repeat (12) @(negedge clk);
            drv_rxd = 1'b1;
            repeat (4) @(negedge clk);
        end
        repeat (idle_after) @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=<%0d cycles", cyc, WATCHDOG);
        finish_run();
    end

    initial begin
        logic [7:0] pat [6];
        int t0, t1, tx0, rxd0, rxe0, highs;
        pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'hA5;
        pat[3] = 8'h3C; pat[4] = 8'h01; pat[5] = 8'h80;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 txd idle", int'(txd), 1);
        chk("R1 tx flags", int'({tx_busy, tx_hold_full}), 0);
        chk("R1 rx_valid", int'(rx_valid), 0);
        chk("R1 error flags", int'({err_parity, err_frame, err_overrun}), 0);
        chk("R1 events", int'({evt_tx_done, evt_rx_done, evt_rx_err}), 0);

        // sweep all parity codes, both stop settings, several bytes, loopback (R2 R3 R4 R8)
        for (int pm = 0; pm < 4; pm++) begin
            for (int ts = 0; ts < 2; ts++) begin
                cfg_parity = 2'(pm);
                cfg_two_stop = ts[0];
                for (int k = 0; k < 6; k++) begin
                    wr_free(pat[k]);
                    expect_frame(pat[k], pm, ts[0], t0);
                    repeat (24) @(negedge clk);
                    chk("R8 rx_valid after frame", int'(rx_valid), 1);
                    chk("R8 rx_data loopback", int'(rx_data), int'(pat[k]));
                    chk("R9 R10 R11 no error in clean frame",
                        int'({err_parity, err_frame, err_overrun}), 0);
                    read_pulse();
                    chk("R8 rx_rd clears rx_valid", int'(rx_valid), 0);
                end
            end
        end
        chk("R7 one tx event per frame", n_tx, 48);
        chk("R8 one rx event per byte", n_rxd, 48);
        chk("R9 no error events in sweep", n_rxe, 0);

        // double buffering, back-to-back spacing, ignored write, overrun (R4 R6 R11)
        cfg_parity = 2'b01;
        cfg_two_stop = 1'b1;
        tx0 = n_tx; rxd0 = n_rxd; rxe0 = n_rxe;
        repeat (40) @(negedge clk);
        fork
            begin
                expect_frame(8'h3C, 1, 1'b1, t0);
                expect_frame(8'hC3, 1, 1'b1, t1);
            end
            begin
                wr_free(8'h3C);
                wr_free(8'hC3);
                chk("R6 second byte waits in holding register", int'({tx_busy, tx_hold_full}), 3);
                tx_write(8'h99);
            end
        join
        chk("R4 back-to-back frame spacing, parity and two stops", t1 - t0, 12 * 16);
        highs = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (txd) highs++;
        end
        chk("R6 write while full ignored: line stays idle", highs, 400);
        chk("R6 R7 exactly two frames sent", n_tx - tx0, 2);
        chk("R11 held byte kept on overrun", int'(rx_data), 8'h3C);
        chk("R11 overrun flag", int'(err_overrun), 1);
        chk("R11 overrun error event", n_rxe - rxe0, 1);
        chk("R11 dropped byte gives no rx event", n_rxd - rxd0, 1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk("R12 err_clr clears flags", int'({err_parity, err_frame, err_overrun}), 0);
        read_pulse();

        // receiver error cases driven directly (R8 R9 R10)
        loop_sel = 1'b0;
        cfg_parity = 2'b01;
        cfg_two_stop = 1'b0;
        rxd0 = n_rxd; rxe0 = n_rxe;
        drv_rxd = 1'b0;
        repeat (4) @(negedge clk);
        drv_rxd = 1'b1;
        repeat (60) @(negedge clk);
        chk("R8 short glitch ignored", int'(rx_valid), 0);
        chk("R8 short glitch gives no event", n_rxd - rxd0, 0);

        send_rx(8'h5A, 1, 1'b1, 1'b1, 20);
        chk("R9 byte delivered despite parity error", int'(rx_data), 8'h5A);
        chk("R9 parity flag", int'({err_parity, err_frame, err_overrun}), 3'b100);
        chk("R9 parity error event", n_rxe - rxe0, 1);
        read_pulse();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;

        cfg_parity = 2'b10;
        rxe0 = n_rxe;
        send_rx(8'h96, 2, 1'b0, 1'b0, 40);
        chk("R10 framing flag", int'({err_parity, err_frame, err_overrun}), 3'b010);
        chk("R10 framing error event", n_rxe - rxe0, 1);
        read_pulse();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;

        // second stop bit not checked by receiver
        cfg_parity = 2'b00;
        cfg_two_stop = 1'b1;
        send_rx(8'h11, 0, 1'b0, 1'b1, 0);
        send_rx(8'h22, 0, 1'b0, 1'b1, 30);
        chk("R10 single stop accepted with two-stop setting", int'(err_frame), 0);
        chk("R10 first byte held", int'(rx_data), 8'h11);
        chk("R11 second byte overruns", int'(err_overrun), 1);
        read_pulse();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;

        // baud divider and clock source (R5)
        loop_sel = 1'b1;
        cfg_two_stop = 1'b0;
        cfg_div = 16'd2;
        wr_free(8'h00);
        while (txd) @(negedge clk);
        t0 = cyc;
        while (!txd) @(negedge clk);
        t1 = cyc;
        chk_rng("R5 nine low bits at div 2", t1 - t0, 429, 433);
        repeat (120) @(negedge clk);
        chk("R5 loopback at div 2", int'({rx_valid, rx_data}), 9'h100);
        read_pulse();

        cfg_clk_sel = 1'b1;
        cfg_div = 16'd1;
        repeat (20) @(negedge clk);
        wr_free(8'h00);
        while (txd) @(negedge clk);
        t0 = cyc;
        while (!txd) @(negedge clk);
        t1 = cyc;
        chk_rng("R5 nine low bits on alt_clk div 1", t1 - t0, 1144, 1153);
        repeat (300) @(negedge clk);
        chk("R5 loopback on alt_clk", int'({rx_valid, rx_data}), 9'h100);
        chk("R12 no stray errors", int'({err_parity, err_frame, err_overrun}), 0);
        read_pulse();

        finish_run();
    end
endmodule